// File: doc/BRIEF.md
# Dual-Rail Pipeline Register Stage

This block is one register stage of a delay-insensitive pipeline in which every logical bit is carried on a pair of wires: a zero rail and a one rail. The stage takes wavefronts from the stage before it, stores them, and shows them to the stage after it. A wavefront is either DATA, with exactly one rail high on every bit, or NULL, with every rail low. The stage takes a new wavefront only when that wavefront is complete on every bit and the downstream request asks for that kind of wavefront. As a result, DATA and NULL alternate strictly on its outputs.

The handshake uses a request input from downstream and an acknowledge output toward upstream. The acknowledge is the inverted completion of the stored word. It is high while the stage holds NULL, which asks upstream for DATA. It is low while the stage holds a complete DATA word, which asks upstream for NULL. A bit with both rails high is illegal. Such a bit is never stored, and it sets an error flag that stays set until reset. For synthesis and verification, the asynchronous behaviour is modelled by sampling every input on the rising clock edge.

Top module: `drr_stage`

## Requirements
- R1: While reset is asserted, and after it is released, both output rail vectors are all zero, `ack_o` is 1 and `err_o` is 0.
- R2: Each bit is the pair {zero rail, one rail}. 00 is NULL, 01 is DATA1, 10 is DATA0 and 11 is illegal. A stored DATA word shows each bit on the output with the same encoding it had at the input.
- R3: When the stage holds NULL, `req_i` is 1 and every input bit is DATA, the stage stores the input word at that edge and `ack_o` becomes 0.
- R4: When the stage holds DATA, `req_i` is 0 and every input bit is NULL, the stage becomes all NULL at that edge and `ack_o` becomes 1.
- R5: An input word that mixes DATA bits and NULL bits leaves the stored word unchanged.
- R6: A complete wavefront whose kind does not match `req_i` leaves the stored word unchanged. This covers DATA while `req_i` is 0 and NULL while `req_i` is 1.
- R7: While the stage holds DATA, a new complete DATA word is not stored, even when `req_i` is 1. Two DATA words always have a NULL between them.
- R8: An input bit with both rails high sets `err_o` at that edge. `err_o` stays set until reset, and the word that contained the illegal bit is never stored.
- R9: `ack_o` is 1 exactly when the stored word is all NULL. The stored word is always either all NULL or all DATA, with no illegal bit.
- R10: In a chain of three stages, every DATA word given to the first stage comes out of the last stage once, unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_zero_i | input | W | Zero rail of each incoming bit |
| in_one_i | input | W | One rail of each incoming bit |
| req_i | input | 1 | Request from downstream: 1 asks for DATA, 0 asks for NULL |
| out_zero_o | output | W | Zero rail of each stored bit |
| out_one_o | output | W | One rail of each stored bit |
| ack_o | output | 1 | Request toward upstream: 1 while holding NULL, 0 while holding DATA |
| err_o | output | 1 | Sticky flag for an illegal rail pair |

## Verification
The stored rails, `ack_o` and `err_o` are all registered. Each reacts at the first rising edge that samples the inputs causing the change, so the result is due one edge after the stimulus. The bench drives inputs on the falling edge and reads the result on the next falling edge, one full edge after the stimulus. In the three-stage chain, the delay depends on the random request timing, so the monitor does not count cycles. It waits on the last stage's acknowledge and compares the word against the scoreboard queue each time that acknowledge falls.

// File: rtl/drr_pkg.sv
package drr_pkg;

  // Rail pair written as {zero rail, one rail}
  typedef enum logic [1:0] {
    RAIL_NULL = 2'b00,
    RAIL_ONE  = 2'b01,
    RAIL_ZERO = 2'b10,
    RAIL_BAD  = 2'b11
  } rail_e;

  function automatic rail_e rail_pair(input logic z, input logic o);
    return rail_e'({z, o});
  endfunction

  function automatic logic rail_is_data(input rail_e c);
    return (c == RAIL_ONE) || (c == RAIL_ZERO);
  endfunction

  function automatic logic rail_is_null(input rail_e c);
    return c == RAIL_NULL;
  endfunction

  function automatic logic rail_is_bad(input rail_e c);
    return c == RAIL_BAD;
  endfunction

endpackage

// File: rtl/drr_rail_decode.sv
module drr_rail_decode
  import drr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] zero_i,
  input  logic [W-1:0] one_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] null_o,
  output logic [W-1:0] bad_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    rail_e cls;
    assign cls       = rail_pair(zero_i[b], one_i[b]);
    assign data_o[b] = rail_is_data(cls);
    assign null_o[b] = rail_is_null(cls);
    assign bad_o[b]  = rail_is_bad(cls);
  end

endmodule

// File: rtl/drr_completion.sv
module drr_completion #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] null_i,
  input  logic [W-1:0] bad_i,
  output logic         all_data_o,
  output logic         all_null_o,
  output logic         any_bad_o
);

  assign all_data_o = &data_i;
  assign all_null_o = &null_i;
  assign any_bad_o  = |bad_i;

endmodule

// File: rtl/drr_hold.sv
module drr_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_zero_i,
  input  logic [W-1:0] in_one_i,
  input  logic         req_i,
  input  logic         in_all_data_i,
  input  logic         in_all_null_i,
  input  logic         in_any_bad_i,
  input  logic         held_null_i,
  input  logic         held_data_i,
  input  logic         held_bad_i,
  output logic [W-1:0] q_zero_o,
  output logic [W-1:0] q_one_o,
  output logic         lat_data_o,
  output logic         lat_null_o,
  output logic         err_o
);

  logic [W-1:0] zero_q, one_q;
  logic         err_q;

  // A DATA word is taken only into an empty stage, and NULL only into a full one
  assign lat_data_o = in_all_data_i & req_i  & held_null_i & ~in_any_bad_i;
  assign lat_null_o = in_all_null_i & ~req_i & held_data_i & ~in_any_bad_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= '0;
      one_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (lat_data_o) begin
        zero_q <= in_zero_i;
        one_q  <= in_one_i;
      end else if (lat_null_o) begin
        zero_q <= '0;
        one_q  <= '0;
      end
      err_q <= err_q | in_any_bad_i | held_bad_i;
    end
  end

  assign q_zero_o = zero_q;
  assign q_one_o  = one_q;
  assign err_o    = err_q;

endmodule

// File: rtl/drr_stage.sv
module drr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_zero_i,
  input  logic [W-1:0] in_one_i,
  input  logic         req_i,
  output logic [W-1:0] out_zero_o,
  output logic [W-1:0] out_one_o,
  output logic         ack_o,
  output logic         err_o
);

  logic [W-1:0] in_data_w, in_null_w, in_bad_w;
  logic [W-1:0] st_data_w, st_null_w, st_bad_w;
  logic         in_all_data_w, in_all_null_w, in_any_bad_w;
  logic         st_all_data_w, st_all_null_w, st_any_bad_w;
  logic         lat_data_w, lat_null_w;
  logic [W-1:0] q_zero_w, q_one_w;

  drr_rail_decode #(.W(W)) u_in_dec (
    .zero_i(in_zero_i), .one_i(in_one_i),
    .data_o(in_data_w), .null_o(in_null_w), .bad_o(in_bad_w)
  );

  drr_completion #(.W(W)) u_in_cmp (
    .data_i(in_data_w), .null_i(in_null_w), .bad_i(in_bad_w),
    .all_data_o(in_all_data_w), .all_null_o(in_all_null_w), .any_bad_o(in_any_bad_w)
  );

  drr_rail_decode #(.W(W)) u_st_dec (
    .zero_i(q_zero_w), .one_i(q_one_w),
    .data_o(st_data_w), .null_o(st_null_w), .bad_o(st_bad_w)
  );

  drr_completion #(.W(W)) u_st_cmp (
    .data_i(st_data_w), .null_i(st_null_w), .bad_i(st_bad_w),
    .all_data_o(st_all_data_w), .all_null_o(st_all_null_w), .any_bad_o(st_any_bad_w)
  );

  drr_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_zero_i(in_zero_i), .in_one_i(in_one_i), .req_i(req_i),
    .in_all_data_i(in_all_data_w), .in_all_null_i(in_all_null_w),
    .in_any_bad_i(in_any_bad_w),
    .held_null_i(st_all_null_w), .held_data_i(st_all_data_w),
    .held_bad_i(st_any_bad_w),
    .q_zero_o(q_zero_w), .q_one_o(q_one_w),
    .lat_data_o(lat_data_w), .lat_null_o(lat_null_w),
    .err_o(err_o)
  );

  assign out_zero_o = q_zero_w;
  assign out_one_o  = q_one_w;
  assign ack_o      = ~st_all_data_w;

endmodule

// File: rtl/drr_stage_chk.sv
module drr_stage_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] in_zero,
  input logic [W-1:0] in_one,
  input logic         req_i,
  input logic [W-1:0] q_zero,
  input logic [W-1:0] q_one,
  input logic         ack_o,
  input logic         err_o,
  input logic         lat_data,
  input logic         lat_null
);

  logic in_full, in_empty, in_bad, held_empty, cap_d, cap_n;
  assign in_full    = &(in_zero ^ in_one);
  assign in_empty   = ~|(in_zero | in_one);
  assign in_bad     = |(in_zero & in_one);
  assign held_empty = ~|(q_zero | q_one);
  assign cap_d      = held_empty && req_i && in_full;
  assign cap_n      = !held_empty && !req_i && in_empty;

  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_d |=> (q_one == $past(in_one)) && (q_zero == $past(in_zero)) && !ack_o); // R3
  AST_NULL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_n |=> ack_o && (q_one == '0) && (q_zero == '0)); // R4
  AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_d && !cap_n) |=> $stable(q_one) && $stable(q_zero)); // R5
  AST_DATA_INTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    lat_data |-> ack_o); // R7
  AST_NULL_INTO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    lat_null |-> !ack_o); // R4
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_bad |=> err_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R8
  AST_OUT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_zero & q_one) == '0); // R9
  AST_OUT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    held_empty || ((q_zero | q_one) == '1)); // R9
  AST_ACK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o == held_empty); // R9

endmodule

bind drr_stage drr_stage_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_zero(in_zero_i), .in_one(in_one_i),
  .req_i(req_i), .q_zero(out_zero_o), .q_one(out_one_o), .ack_o(ack_o),
  .err_o(err_o), .lat_data(lat_data_w), .lat_null(lat_null_w)
);

// File: tb/drr_stage_tb.sv
module drr_stage_tb_top;
  localparam int W      = 8;
  localparam int NITEMS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // single stage under directed test
  logic [W-1:0] d_zero = '0, d_one = '0;
  logic         d_req = 1'b0;
  logic [W-1:0] q_zero, q_one;
  logic         d_ack, d_err;

  drr_stage #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_zero_i(d_zero), .in_one_i(d_one),
    .req_i(d_req), .out_zero_o(q_zero), .out_one_o(q_one),
    .ack_o(d_ack), .err_o(d_err)
  );

  // three-stage chain
  logic [W-1:0] c_zero = '0, c_one = '0;
  logic         cons_req = 1'b1;
  logic [W-1:0] l0_zero, l0_one, l1_zero, l1_one, l2_zero, l2_one;
  logic         a0, a1, a2, e0, e1, e2;

  drr_stage #(.W(W)) ch0_i (.clk(clk), .rst_n(rst_n), .in_zero_i(c_zero), .in_one_i(c_one),
    .req_i(a1), .out_zero_o(l0_zero), .out_one_o(l0_one), .ack_o(a0), .err_o(e0));
  drr_stage #(.W(W)) ch1_i (.clk(clk), .rst_n(rst_n), .in_zero_i(l0_zero), .in_one_i(l0_one),
    .req_i(a2), .out_zero_o(l1_zero), .out_one_o(l1_one), .ack_o(a1), .err_o(e1));
  drr_stage #(.W(W)) ch2_i (.clk(clk), .rst_n(rst_n), .in_zero_i(l1_zero), .in_one_i(l1_one),
    .req_i(cons_req), .out_zero_o(l2_zero), .out_one_o(l2_one), .ack_o(a2), .err_o(e2));

  logic [W-1:0] exp_q[$];

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [W-1:0] z, input logic [W-1:0] o, input logic r);
    d_zero = z;
    d_one  = o;
    d_req  = r;
  endtask

  task automatic produce();
    for (int i = 0; i < NITEMS; i++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      while (!a0) @(negedge clk);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      c_one  = v & 8'hF0;      // skewed arrival: partial first
      c_zero = ~v & 8'hF0;
      @(negedge clk);
      c_one  = v;
      c_zero = ~v;
      exp_q.push_back(v);
      while (a0) @(negedge clk);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      c_one  = '0;
      c_zero = '0;
      while (!a0) @(negedge clk);
    end
  endtask

  task automatic consume();
    for (int i = 0; i < NITEMS; i++) begin
      logic [W-1:0] got;
      while (a2) @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 unexpected word actual=%h expected=none", l2_one);
      end else begin
        got = exp_q.pop_front();
        chk("R10", l2_one, got, "chain output one rail");
        chk("R2", l2_zero, ~got, "chain output zero rail");
      end
      repeat ($urandom_range(0, 4)) @(negedge clk);
      cons_req = 1'b0;
      while (!a2) @(negedge clk);
      repeat ($urandom_range(0, 4)) @(negedge clk);
      cons_req = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", q_one | q_zero, '0, "rails in reset");
    chk("R1", {7'd0, d_ack}, 8'd1, "ack in reset");
    rst_n = 1'b1;
    step();
    chk("R1", q_one | q_zero, '0, "rails after reset");
    chk("R1", {6'd0, d_ack, d_err}, 8'd2, "ack/err after reset");

    put(~8'hA5, 8'hA5, 1'b0); step();
    chk("R6", q_one, 8'h00, "DATA ignored while NULL requested");
    chk("R6", {7'd0, d_ack}, 8'd1, "ack unchanged");

    put(~8'hA5 & 8'h0F, 8'hA5 & 8'h0F, 1'b1); step();
    chk("R5", q_one | q_zero, 8'h00, "partial DATA ignored");

    put(~8'hA5, 8'hA5, 1'b1); step();
    chk("R3", q_one, 8'hA5, "DATA stored one rail");
    chk("R2", q_zero, 8'h5A, "DATA stored zero rail");
    chk("R3", {7'd0, d_ack}, 8'd0, "ack low holding DATA");

    put(~8'h3C, 8'h3C, 1'b1); step();
    chk("R7", q_one, 8'hA5, "second DATA without NULL ignored");

    put('0, '0, 1'b1); step();
    chk("R6", q_one, 8'hA5, "NULL ignored while DATA requested");

    put(~8'h3C & 8'h0F, 8'h3C & 8'h0F, 1'b0); step();
    chk("R5", q_one, 8'hA5, "partial NULL ignored");

    put('0, '0, 1'b0); step();
    chk("R4", q_one | q_zero, 8'h00, "NULL stored");
    chk("R4", {7'd0, d_ack}, 8'd1, "ack high holding NULL");

    put(8'hFF, 8'h00, 1'b1); step();
    chk("R2", q_zero, 8'hFF, "all DATA0 zero rail");
    chk("R9", {7'd0, d_ack}, 8'd0, "ack low on full word");
    put('0, '0, 1'b0); step();
    put(8'h00, 8'hFF, 1'b1); step();
    chk("R2", q_one, 8'hFF, "all DATA1 one rail");
    put('0, '0, 1'b0); step();
    chk("R9", {7'd0, d_ack}, 8'd1, "ack high after NULL");

    put(~8'hA5, 8'hA5 | 8'h08, 1'b1); step();
    chk("R8", {7'd0, d_err}, 8'd1, "error set on illegal pair");
    chk("R8", q_one | q_zero, 8'h00, "illegal word not stored");

    put('0, '0, 1'b1); step();
    chk("R8", {7'd0, d_err}, 8'd1, "error sticky");

    put(~8'h66, 8'h66, 1'b1); step();
    chk("R3", q_one, 8'h66, "DATA stored after error");

    put(8'h01, 8'h01, 1'b0); step();
    chk("R8", q_one, 8'h66, "illegal NULL-like word not stored");

    rst_n = 1'b0; step();
    chk("R1", {6'd0, d_ack, d_err}, 8'd2, "reset clears error");
    chk("R1", q_one | q_zero, 8'h00, "reset clears word");
    rst_n = 1'b1; step();

    fork
      produce();
      consume();
    join
    chk("R10", W'(exp_q.size()), 8'd0, "no words left over");
    chk("R8", {5'd0, e0, e1, e2}, 8'd0, "no error in chain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule